// File: doc/BRIEF.md
# Tag Invalidation Sequencer with Key Rotation

This block clears a scrambled tag store. A flush request, such as one raised by an instruction fence, starts an invalidation. The block first asks for a fresh scrambling key with a one-cycle request. It then waits until the key source reports the new key as usable. After that it writes an all-zero (invalid) word to every tag index, one index per clock, and finally pulses a completion flag. While any of this is under way, a busy flag tells the surrounding cache to hold off lookups.

Each invalidation is paired with a key change. A flush request that lands while work is in progress throws the current work away. The block then starts over with a new key request and a sweep from index zero. This holds even when the request arrives in the cycle that writes the last index, so the key is never rotated without every entry being wiped under it. Leaving reset counts as a flush: the block performs one full invalidation on its own before the cache may be used.

The control is a five-state machine: idle, key request, key wait, sweep and done. All outputs are decoded from the registered state and the registered index counter.

Top module: `tagwipe_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the block sits in its key-request state: key_refresh_o=1, busy_o=1, tag_we_o=0, done_o=0. An invalidation then proceeds with no flush request.
- R2: key_refresh_o is high for exactly one cycle per key request. A flush request sampled during that key-request cycle is absorbed and does not produce a second pulse.
- R3: After the key request the block waits while key_ok_i is low. During the wait no tag write and no done pulse occur, and busy_o stays high. The sweep starts the cycle after key_ok_i is sampled high.
- R4: The sweep writes indices 0 to NUM_SETS-1 in ascending order, one per consecutive cycle, with tag_we_o=1 and tag_wdata_o all zeros.
- R5: done_o is high for one cycle, in the cycle right after the write of index NUM_SETS-1. busy_o drops in the following cycle.
- R6: busy_o is high in every cycle from the key request through the done pulse, and low in idle.
- R7: A flush request sampled during a sweep cycle other than the last gives a key-request cycle next. No further writes follow until a new key is valid, and the sweep then starts again from index 0.
- R8: A flush request sampled in the sweep cycle that writes the last index gives no done pulse. It restarts exactly as in R7.
- R9: A flush request sampled while waiting for the key gives a fresh key-request pulse in the next cycle.
- R10: A flush request sampled in the done cycle leaves that done pulse in place, and a new key-request cycle follows at once.
- R11: In idle with no flush request, all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_req_i | input | 1 | Invalidation request, sampled each cycle |
| key_ok_i | input | 1 | New scrambling key is valid |
| key_refresh_o | output | 1 | One-cycle request for a new scrambling key |
| tag_idx_o | output | $clog2(NUM_SETS) | Tag index being written |
| tag_we_o | output | 1 | Tag write enable |
| tag_wdata_o | output | TAG_W | Tag write data, always the invalid (all-zero) word |
| busy_o | output | 1 | Invalidation in progress, lookups blocked |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong state shows up at the ports within one cycle, because every output is a direct decode of the state and index registers. A machine stuck in the wait state keeps busy high with no writes. A counter that fails to clear on restart shows a nonzero first index on the cycle tag_we_o rises. A missed last-cycle restart shows as a done pulse where a key-request pulse was due. The directed scenarios place a flush request in each state and check the very next cycle's outputs. Each scenario then follows the complete sweep that comes after.

// File: rtl/tagwipe_pkg.sv
package tagwipe_pkg;

    typedef enum logic [2:0] {
        WS_IDLE    = 3'd0,
        WS_KEYREQ  = 3'd1,
        WS_KEYWAIT = 3'd2,
        WS_SWEEP   = 3'd3,
        WS_DONE    = 3'd4
    } wipe_state_e;

    typedef struct packed {
        logic key_refresh;
        logic tag_we;
        logic busy;
        logic done;
    } wipe_ctl_t;

    // Moore decode of the control strobes from the state register.
    function automatic wipe_ctl_t decode_ctl(wipe_state_e s);
        wipe_ctl_t c;
        c.key_refresh = (s == WS_KEYREQ);
        c.tag_we      = (s == WS_SWEEP);
        c.busy        = (s != WS_IDLE);
        c.done        = (s == WS_DONE);
        return c;
    endfunction

    // Next state, given the flush request, key status and sweep end.
    function automatic wipe_state_e next_state(wipe_state_e s, logic flush,
                                              logic key_ok, logic last);
        wipe_state_e n;
        n = s;
        unique case (s)
            WS_IDLE:    n = flush ? WS_KEYREQ : WS_IDLE;
            // A request in the key-request cycle is already being served.
            WS_KEYREQ:  n = WS_KEYWAIT;
            WS_KEYWAIT: n = flush ? WS_KEYREQ : (key_ok ? WS_SWEEP : WS_KEYWAIT);
            WS_SWEEP:   n = flush ? WS_KEYREQ : (last ? WS_DONE : WS_SWEEP);
            WS_DONE:    n = flush ? WS_KEYREQ : WS_IDLE;
            default:    n = WS_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tagwipe_fsm.sv
module tagwipe_fsm
    import tagwipe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush_req,
    input  logic        key_ok,
    input  logic        sweep_last,
    output wipe_state_e state
);

    wipe_state_e state_q;
    wipe_state_e state_d;

    always_comb begin
        state_d = next_state(state_q, flush_req, key_ok, sweep_last);
    end

    // Reset lands in the key-request state: one automatic invalidation.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_KEYREQ;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    // R2: the key-request state never lasts two cycles.
    p_keyreq_once_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_KEYREQ) |=> (state_q == WS_KEYWAIT));

    // R3: the sweep is entered only from the wait state with a valid key.
    p_sweep_needs_key_r3: assert property (@(posedge clk) disable iff (rst)
        ((state_q == WS_SWEEP) && ($past(state_q) != WS_SWEEP))
            |-> ($past(state_q) == WS_KEYWAIT) && $past(key_ok));

endmodule

// File: rtl/tagwipe_idx.sv
module tagwipe_idx #(
    parameter int NUM_SETS = 64,
    localparam int IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SETS - 1);

    logic [IDX_W-1:0] idx_q;

    assign last = (idx_q == LAST_IDX);

    // Counts while stepping; any cycle without a step clears it to zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (step && !last) begin
            idx_q <= idx_q + 1'b1;
        end else begin
            idx_q <= '0;
        end
    end

    assign idx = idx_q;

    // R4: a step from below the end advances by exactly one.
    p_idx_advance_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !last) |=> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/tagwipe_ctrl.sv
module tagwipe_ctrl
    import tagwipe_pkg::*;
#(
    parameter int NUM_SETS = 64,
    parameter int TAG_W    = 22,
    localparam int IDX_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_req_i,
    input  logic             key_ok_i,
    output logic             key_refresh_o,
    output logic [IDX_W-1:0] tag_idx_o,
    output logic             tag_we_o,
    output logic [TAG_W-1:0] tag_wdata_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SETS - 1);

    wipe_state_e      state;
    wipe_ctl_t        ctl;
    logic             sweep_last;
    logic             sweep_step;
    logic [IDX_W-1:0] idx;

    tagwipe_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .flush_req  (flush_req_i),
        .key_ok     (key_ok_i),
        .sweep_last (sweep_last),
        .state      (state)
    );

    // A restart request stops the count so the next sweep begins at zero.
    assign sweep_step = (state == WS_SWEEP) && !flush_req_i;

    tagwipe_idx #(
        .NUM_SETS (NUM_SETS)
    ) u_idx (
        .clk  (clk),
        .rst  (rst),
        .step (sweep_step),
        .idx  (idx),
        .last (sweep_last)
    );

    assign ctl           = decode_ctl(state);
    assign key_refresh_o = ctl.key_refresh;
    assign tag_we_o      = ctl.tag_we;
    assign busy_o        = ctl.busy;
    assign done_o        = ctl.done;
    assign tag_idx_o     = idx;
    assign tag_wdata_o   = '0;

    // R2: the key request is a single-cycle pulse.
    p_key_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        key_refresh_o |=> !key_refresh_o);

    // R5: done is a single-cycle pulse.
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5 and R8: done only directly after the last index was written.
    p_done_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(tag_we_o) && ($past(tag_idx_o) == LAST_IDX)));

    // R7: every sweep starts at index zero.
    p_sweep_from_zero_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tag_we_o) |-> (tag_idx_o == '0));

    // R6: any activity strobe implies busy.
    p_busy_cover_r6: assert property (@(posedge clk) disable iff (rst)
        (key_refresh_o || tag_we_o || done_o) |-> busy_o);

    // R3: writes follow a key request only after a valid key was seen.
    p_no_write_after_req_r3: assert property (@(posedge clk) disable iff (rst)
        key_refresh_o |=> !tag_we_o);

endmodule

// File: tb/sim_tagwipe_ctrl.sv
`timescale 1ns/1ps
module sim_tagwipe_ctrl;

    localparam int N     = 8;
    localparam int IW    = 3;
    localparam int TW    = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          flush_req;
    logic          key_ok;
    logic          key_refresh;
    logic [IW-1:0] tag_idx;
    logic          tag_we;
    logic [TW-1:0] tag_wdata;
    logic          busy;
    logic          done;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tagwipe_ctrl #(.NUM_SETS(N), .TAG_W(TW)) u0 (
        .clk           (clk),
        .rst           (rst),
        .flush_req_i   (flush_req),
        .key_ok_i      (key_ok),
        .key_refresh_o (key_refresh),
        .tag_idx_o     (tag_idx),
        .tag_we_o      (tag_we),
        .tag_wdata_o   (tag_wdata),
        .busy_o        (busy),
        .done_o        (done)
    );

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Vector order {key_refresh, tag_we, busy, done}.
    task automatic chk_vec(string req, logic [3:0] exp);
        chk(req, "strobes{kr,we,busy,done}", int'({key_refresh, tag_we, busy, done}), int'(exp));
    endtask

    // Caller stands at the sample of index 0; ends at the sample of index n-1.
    task automatic sweep_upto(string req, int n);
        for (int i = 0; i < n; i++) begin
            if (i > 0) tick();
            chk_vec(req, 4'b0110);
            chk(req, "tag index", int'(tag_idx), i);
            chk(req, "tag wdata", int'(tag_wdata), 0);
        end
    endtask

    task automatic sweep_full(string req);
        sweep_upto(req, N);
        tick();
        chk_vec("R5", 4'b0011);
        tick();
        chk_vec("R5", 4'b0000);
    endtask

    // Flush pulse from idle; ends at the sample of index 0.
    task automatic start_from_idle;
        flush_req = 1'b1;
        tick();
        flush_req = 1'b0;
        chk_vec("R2", 4'b1010);
        tick();
        chk_vec("R3", 4'b0010);
        tick();
    endtask

    task automatic t_reset_and_boot;
        rst = 1'b1; flush_req = 1'b0; key_ok = 1'b0;
        repeat (3) tick();
        chk_vec("R1", 4'b1010);
        rst = 1'b0;
        tick();
        chk_vec("R2", 4'b0010);
        repeat (5) begin
            tick();
            chk_vec("R3", 4'b0010);
        end
        key_ok = 1'b1;
        tick();
        sweep_full("R4");
    endtask

    task automatic t_idle_quiet;
        repeat (4) begin
            tick();
            chk_vec("R11", 4'b0000);
        end
    endtask

    task automatic t_req_in_keyreq;
        flush_req = 1'b1;
        tick();
        chk_vec("R2", 4'b1010);
        tick();
        flush_req = 1'b0;
        chk_vec("R2", 4'b0010);
        tick();
        sweep_full("R2");
    endtask

    task automatic t_mid_restart;
        start_from_idle();
        sweep_upto("R7", 4);
        flush_req = 1'b1;
        tick();
        flush_req = 1'b0;
        chk_vec("R7", 4'b1010);
        tick();
        chk_vec("R7", 4'b0010);
        tick();
        sweep_full("R7");
    endtask

    task automatic t_last_restart;
        start_from_idle();
        sweep_upto("R8", N);
        flush_req = 1'b1;
        tick();
        flush_req = 1'b0;
        chk_vec("R8", 4'b1010);
        tick();
        chk_vec("R8", 4'b0010);
        tick();
        sweep_full("R8");
    endtask

    task automatic t_keywait_restart;
        key_ok = 1'b0;
        flush_req = 1'b1;
        tick();
        flush_req = 1'b0;
        chk_vec("R9", 4'b1010);
        tick();
        chk_vec("R9", 4'b0010);
        tick();
        chk_vec("R9", 4'b0010);
        flush_req = 1'b1;
        tick();
        flush_req = 1'b0;
        chk_vec("R9", 4'b1010);
        tick();
        chk_vec("R9", 4'b0010);
        key_ok = 1'b1;
        tick();
        sweep_full("R9");
    endtask

    task automatic t_done_restart;
        start_from_idle();
        sweep_upto("R10", N);
        tick();
        chk_vec("R10", 4'b0011);
        flush_req = 1'b1;
        tick();
        flush_req = 1'b0;
        chk_vec("R10", 4'b1010);
        tick();
        chk_vec("R10", 4'b0010);
        tick();
        sweep_full("R6");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; flush_req = 1'b0; key_ok = 1'b0;
        t_reset_and_boot();
        t_idle_quiet();
        t_req_in_keyreq();
        t_mid_restart();
        t_last_restart();
        t_keywait_restart();
        t_done_restart();
        t_idle_quiet();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule